// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sequences the two sleep depths of a small microcontroller. Software starts a sleep by writing a byte to the mode control register. One bit requests a deep stop and another requests a light pause. In the deep stop, Halt, the oscillator, the comparator and the brown-out detector are all switched off. Only an event from the multi-input wakeup logic can end Halt. The block then switches the oscillator and analog circuits back on. It holds the CPU stopped for a fixed recovery count before letting it run again. In the light pause, Idle, only the CPU-run signal drops. A timer 0 overflow or a wakeup event brings the CPU back on the next cycle.

The block records which source ended each sleep in a wake-flag register. A new sleep request is refused while any flag is still set. Software acknowledges a wakeup by writing 0x00 to that register, which clears the flags. The request bits in the mode control register are write-only and have no storage, so they read back as zero.

The controller has four states: RUN, IDLE, HALT and RECOVER. It has these transitions:
- RUN→HALT on a halt request.
- RUN→IDLE on an idle request.
- HALT→RECOVER on a wakeup event.
- RECOVER→RUN when the recovery count expires.
- IDLE→RUN on a wakeup event or a timer overflow.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the block is in RUN. osc_en, cmp_en, bod_en and cpu_run are 1, and the wake flags are 0.
- R2: A write to address 0xB7 in RUN, with no wake flag set, takes effect at the next clock edge. If bit 0 is set, the block enters HALT, even when bit 1 is also set. If only bit 1 is set, the block enters IDLE. Bits 7:2 have no effect. Writes to 0xB7 in any other state are ignored.
- R3: In HALT, osc_en, cmp_en, bod_en and cpu_run are all 0.
- R4: HALT is left only when wake_evt is high at a clock edge. tmr_ovf has no effect in HALT.
- R5: A wakeup from HALT sets wake flag bit 0 and enters RECOVER. RECOVER lasts exactly REC_CYCLES cycles, with osc_en, cmp_en and bod_en at 1 and cpu_run at 0. The block then returns to RUN.
- R6: In IDLE, osc_en, cmp_en and bod_en stay 1 and cpu_run is 0. A wake_evt or tmr_ovf at a clock edge returns the block to RUN in the next cycle.
- R7: The wake flags read at address 0xB8. Bit 0 means a wakeup event ended the sleep and bit 1 means a timer overflow ended an Idle. Both bits are set if both sources were present, and bits 7:2 read 0.
- R8: Writing 0x00 to address 0xB8 clears the wake flags. A nonzero write to 0xB8 leaves them unchanged.
- R9: A write to 0xB7 in RUN is ignored while any wake flag is set.
- R10: Reading address 0xB7, or any address other than 0xB8, returns 0x00.
- R11: mode_state shows the state as RUN=0, IDLE=1, HALT=2, RECOVER=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| wake_evt | input | 1 | Wakeup event from multi-input wakeup logic |
| tmr_ovf | input | 1 | Timer 0 overflow pulse |
| osc_en | output | 1 | Oscillator enable |
| cmp_en | output | 1 | Comparator enable |
| bod_en | output | 1 | Brown-out detector enable |
| cpu_run | output | 1 | CPU clock enable |
| mode_state | output | 2 | Current mode (encoding in R11) |

## Verification
The register writes, wake_evt and tmr_ovf are all sampled at one rising edge. Their effect on mode_state, on the enables and on the wake flags is visible right after that edge. RECOVER then holds for REC_CYCLES further edges before cpu_run returns. rd_data follows rd_addr and the flags with no delay. The bench changes inputs on the falling edge and moves a behavioural model at each rising edge. It compares every output on the next falling edge, so each result is checked in the very cycle it is due.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN     = 2'd0,
        PM_IDLE    = 2'd1,
        PM_HALT    = 2'd2,
        PM_RECOVER = 2'd3
    } pm_state_e;

    localparam int FLAG_EXT = 0;
    localparam int FLAG_TMR = 1;
    localparam int FLAG_W   = 2;

endpackage

// File: rtl/pms_regif.sv
module pms_regif
    import pwr_mode_pkg::*;
#(
    parameter int          DW        = 8,
    parameter int          AW        = 8,
    parameter logic [7:0]  ADDR_MODE = 8'hB7,
    parameter logic [7:0]  ADDR_ACK  = 8'hB8
) (
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic [FLAG_W-1:0] flags,
    output logic              req_halt,
    output logic              req_idle,
    output logic              ack_clr,
    output logic [DW-1:0]     rd_data
);

    logic mode_hit;

    always_comb begin
        mode_hit = wr_en && (wr_addr == AW'(ADDR_MODE));
        req_halt = mode_hit && wr_data[0];
        req_idle = mode_hit && wr_data[1] && !wr_data[0];
        ack_clr  = wr_en && (wr_addr == AW'(ADDR_ACK)) && (wr_data == '0);
        rd_data  = '0;
        if (rd_addr == AW'(ADDR_ACK))
            rd_data[FLAG_W-1:0] = flags;
    end

endmodule

// File: rtl/pms_wake_log.sv
module pms_wake_log
    import pwr_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_ext,
    input  logic              set_tmr,
    input  logic              clr,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[FLAG_EXT] = set_ext;
        set_vec[FLAG_TMR] = set_tmr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (clr ? '0 : flags) | set_vec;
    end

endmodule

// File: rtl/pms_recover_timer.sv
module pms_recover_timer #(
    parameter int REC_CYCLES = 16,
    localparam int CNT_W     = $clog2(REC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!active || done)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign done = active && (cnt == CNT_W'(REC_CYCLES - 1));

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
    import pwr_mode_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_halt,
    input  logic      req_idle,
    input  logic      pending,
    input  logic      wake_evt,
    input  logic      tmr_ovf,
    input  logic      rec_done,
    output pm_state_e state,
    output logic      osc_en,
    output logic      cmp_en,
    output logic      bod_en,
    output logic      cpu_run,
    output logic      set_ext,
    output logic      set_tmr
);

    pm_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= PM_RUN;
        else
            state <= nxt;
    end

    always_comb begin
        nxt     = state;
        set_ext = 1'b0;
        set_tmr = 1'b0;
        unique case (state)
            PM_RUN: begin
                if (!pending && req_halt)
                    nxt = PM_HALT;
                else if (!pending && req_idle)
                    nxt = PM_IDLE;
            end
            PM_HALT: begin
                if (wake_evt) begin
                    nxt     = PM_RECOVER;
                    set_ext = 1'b1;
                end
            end
            PM_RECOVER: begin
                if (rec_done)
                    nxt = PM_RUN;
            end
            PM_IDLE: begin
                if (wake_evt || tmr_ovf) begin
                    nxt     = PM_RUN;
                    set_ext = wake_evt;
                    set_tmr = tmr_ovf;
                end
            end
        endcase
    end

    always_comb begin
        osc_en  = 1'b1;
        cmp_en  = 1'b1;
        bod_en  = 1'b1;
        cpu_run = 1'b0;
        unique case (state)
            PM_RUN:     cpu_run = 1'b1;
            PM_IDLE:    ;
            PM_RECOVER: ;
            PM_HALT: begin
                osc_en = 1'b0;
                cmp_en = 1'b0;
                bod_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter logic [7:0] ADDR_MODE  = 8'hB7,
    parameter logic [7:0] ADDR_ACK   = 8'hB8,
    parameter int         REC_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       wake_evt,
    input  logic       tmr_ovf,
    output logic       osc_en,
    output logic       cmp_en,
    output logic       bod_en,
    output logic       cpu_run,
    output logic [1:0] mode_state
);

    logic              req_halt, req_idle, ack_clr;
    logic              set_ext, set_tmr, rec_done;
    logic [FLAG_W-1:0] ack_q;
    pm_state_e         st;

    pms_regif #(
        .DW(8), .AW(8), .ADDR_MODE(ADDR_MODE), .ADDR_ACK(ADDR_ACK)
    ) u_regif (
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .flags(ack_q),
        .req_halt(req_halt), .req_idle(req_idle),
        .ack_clr(ack_clr), .rd_data(rd_data)
    );

    pms_wake_log u_log (
        .clk(clk), .rst_n(rst_n), .set_ext(set_ext), .set_tmr(set_tmr),
        .clr(ack_clr), .flags(ack_q)
    );

    pms_recover_timer #(.REC_CYCLES(REC_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .active(st == PM_RECOVER), .done(rec_done)
    );

    pms_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_halt(req_halt), .req_idle(req_idle),
        .pending(|ack_q), .wake_evt(wake_evt), .tmr_ovf(tmr_ovf),
        .rec_done(rec_done), .state(st), .osc_en(osc_en), .cmp_en(cmp_en),
        .bod_en(bod_en), .cpu_run(cpu_run), .set_ext(set_ext), .set_tmr(set_tmr)
    );

    assign mode_state = st;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk
    import pwr_mode_pkg::*;
#(
    parameter logic [7:0] ADDR_MODE  = 8'hB7,
    parameter int         REC_CYCLES = 16,
    localparam int        LW         = $clog2(REC_CYCLES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic [1:0]        wr_low,
    input logic              wake_evt,
    input logic              tmr_ovf,
    input logic [1:0]        mode_state,
    input logic              osc_en,
    input logic              cmp_en,
    input logic              bod_en,
    input logic              cpu_run,
    input logic [FLAG_W-1:0] flags
);

    logic [LW-1:0] rec_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rec_len <= '0;
        else if (mode_state == PM_RECOVER)
            rec_len <= rec_len + 1'b1;
        else
            rec_len <= '0;
    end

    a_r2_halt_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == PM_RUN && flags == '0 && wr_en && wr_addr == ADDR_MODE && wr_low[0])
        |=> mode_state == PM_HALT);

    a_r3_halt_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == PM_HALT) |-> (!osc_en && !cmp_en && !bod_en && !cpu_run));

    a_r4_halt_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == PM_HALT && !wake_evt) |=> mode_state == PM_HALT);

    a_r5_wake_to_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == PM_HALT && wake_evt) |=> (mode_state == PM_RECOVER && flags[FLAG_EXT]));

    a_r5_recover_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == PM_RECOVER) |-> (rec_len < LW'(REC_CYCLES) && !cpu_run && osc_en));

    a_r5_recover_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == PM_RECOVER && rec_len == LW'(REC_CYCLES - 1)) |=> mode_state == PM_RUN);

    a_r6_idle_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == PM_IDLE && (wake_evt || tmr_ovf)) |=> (mode_state == PM_RUN && cpu_run));

    a_r9_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == PM_RUN && flags != '0) |=> mode_state == PM_RUN);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk #(
    .ADDR_MODE(ADDR_MODE), .REC_CYCLES(REC_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_low(wr_data[1:0]), .wake_evt(wake_evt), .tmr_ovf(tmr_ovf),
    .mode_state(mode_state), .osc_en(osc_en), .cmp_en(cmp_en),
    .bod_en(bod_en), .cpu_run(cpu_run), .flags(ack_q)
);

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;

    localparam int REC = 6;
    localparam logic [7:0] A_MODE = 8'hB7;
    localparam logic [7:0] A_ACK  = 8'hB8;
    localparam int S_RUN = 0, S_IDLE = 1, S_HALT = 2, S_REC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_addr = A_ACK;
    logic       wake_evt = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic [7:0] rd_data;
    logic       osc_en, cmp_en, bod_en, cpu_run;
    logic [1:0] mode_state;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int m_st = S_RUN;
    int m_left = 0;
    int m_flags = 0;

    always #5 clk = ~clk;

    pwr_mode_seq #(.REC_CYCLES(REC)) u_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wake_evt(wake_evt), .tmr_ovf(tmr_ovf), .osc_en(osc_en),
        .cmp_en(cmp_en), .bod_en(bod_en), .cpu_run(cpu_run),
        .mode_state(mode_state)
    );

    // Behavioural reference model, advanced at every rising edge
    always @(posedge clk) begin
        int nf;
        if (!rst_n) begin
            m_st = S_RUN; m_left = 0; m_flags = 0;
        end else begin
            nf = (wr_en && wr_addr == A_ACK && wr_data == 8'h00) ? 0 : m_flags;
            case (m_st)
                S_RUN:
                    if (wr_en && wr_addr == A_MODE && m_flags == 0) begin
                        if (wr_data[0]) m_st = S_HALT;
                        else if (wr_data[1]) m_st = S_IDLE;
                    end
                S_HALT:
                    if (wake_evt) begin
                        m_st = S_REC; m_left = REC; nf = nf | 1;
                    end
                S_REC: begin
                    m_left = m_left - 1;
                    if (m_left == 0) m_st = S_RUN;
                end
                default:
                    if (wake_evt || tmr_ovf) begin
                        m_st = S_RUN;
                        nf = nf | (wake_evt ? 1 : 0) | (tmr_ovf ? 2 : 0);
                    end
            endcase
            m_flags = nf;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string st_tag(int s);
        case (s)
            S_HALT:  return "R3";
            S_REC:   return "R5";
            S_IDLE:  return "R6";
            default: return "R1";
        endcase
    endfunction

    // Compare all outputs against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R11 mode_state", {6'd0, mode_state}, 8'(m_st));
            check({st_tag(m_st), " osc_en"}, {7'd0, osc_en}, {7'd0, m_st != S_HALT});
            check({st_tag(m_st), " cmp_en"}, {7'd0, cmp_en}, {7'd0, m_st != S_HALT});
            check({st_tag(m_st), " bod_en"}, {7'd0, bod_en}, {7'd0, m_st != S_HALT});
            check({st_tag(m_st), " cpu_run"}, {7'd0, cpu_run}, {7'd0, m_st == S_RUN});
            if (rd_addr == A_ACK)
                check("R7 rd_data", rd_data, 8'(m_flags));
            else
                check("R10 rd_data", rd_data, 8'h00);
        end
    end

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(logic w, logic t);
        @(negedge clk);
        wake_evt = w; tmr_ovf = t;
        @(negedge clk);
        wake_evt = 1'b0; tmr_ovf = 1'b0;
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset cpu_run", {7'd0, cpu_run}, 8'd1);
        check("R1 reset osc_en", {7'd0, osc_en}, 8'd1);
        check("R1 reset flags", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        wr(A_MODE, 8'h03);
        check("R2 halt has priority", {6'd0, mode_state}, 8'd2);
        pulse(1'b0, 1'b1);
        pulse(1'b0, 1'b1);
        check("R4 timer ignored in halt", {6'd0, mode_state}, 8'd2);
        pulse(1'b1, 1'b0);
        check("R5 recover entered", {6'd0, mode_state}, 8'd3);
        repeat (REC - 1) @(negedge clk);
        check("R5 recover last cycle", {7'd0, cpu_run}, 8'd0);
        @(negedge clk);
        check("R5 back to run", {6'd0, mode_state}, 8'd0);
        check("R7 ext flag", rd_data, 8'h01);

        wr(A_MODE, 8'h02);
        check("R9 entry blocked while pending", {6'd0, mode_state}, 8'd0);
        wr(A_ACK, 8'h05);
        check("R8 nonzero ack ignored", rd_data, 8'h01);
        wr(A_ACK, 8'h00);
        check("R8 ack clears", rd_data, 8'h00);

        wr(A_MODE, 8'h02);
        check("R2 idle entry", {6'd0, mode_state}, 8'd1);
        wr(A_MODE, 8'h01);
        check("R2 write ignored in idle", {6'd0, mode_state}, 8'd1);
        repeat (3) @(negedge clk);
        pulse(1'b0, 1'b1);
        check("R6 timer exits idle", {6'd0, mode_state}, 8'd0);
        check("R7 timer flag", rd_data, 8'h02);
        wr(A_ACK, 8'h00);

        wr(A_MODE, 8'h02);
        pulse(1'b1, 1'b0);
        check("R6 wake exits idle", {7'd0, cpu_run}, 8'd1);
        check("R7 wake flag from idle", rd_data, 8'h01);
        wr(A_ACK, 8'h00);

        wr(A_MODE, 8'h02);
        pulse(1'b1, 1'b1);
        check("R7 both flags", rd_data, 8'h03);
        wr(A_ACK, 8'h00);

        wr(A_MODE, 8'hFC);
        check("R2 reserved bits no effect", {6'd0, mode_state}, 8'd0);
        wr(8'h40, 8'h01);
        check("R2 other address no effect", {6'd0, mode_state}, 8'd0);
        rd_addr = A_MODE;
        @(negedge clk);
        check("R10 mode reg reads zero", rd_data, 8'h00);
        rd_addr = A_ACK;

        wr(A_MODE, 8'h01);
        pulse(1'b1, 1'b1);
        check("R5 halt wake sets only ext", rd_data, 8'h01);
        repeat (REC + 2) @(negedge clk);
        check("R5 run after recovery", {7'd0, cpu_run}, 8'd1);
        wr(A_ACK, 8'h00);
        repeat (2) @(negedge clk);

        finish_up();
    end

endmodule